// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU With Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it takes an operation code, a register operand (the accumulator, or an index register for compares and the unary operations), a memory operand and the current status byte. One clock edge later it presents the 8-bit result and the new status byte. Each operation updates only the negative, overflow, zero and carry flags it is defined to touch. Every other status bit is copied from the incoming byte.

The operations are:

- add with carry and subtract with borrow, both always binary;
- compare;
- AND, OR and XOR;
- bit test;
- shift left and logical shift right;
- rotate left and rotate right through carry;
- increment and decrement.

The unary operations act on the register operand. Compare and bit test leave the register operand on the result output unchanged. Instruction decode and operand fetch belong to the surrounding core.

Status byte layout: N is bit 7, V bit 6, bit 5 always reads 1, B bit 4, D bit 3, I bit 2, Z bit 1, C bit 0.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = reg + mem + C (mod 256). C is set when the 9-bit sum exceeds 255. V is set when both operands have the same sign and the result sign differs from it. N is result bit 7, and Z is set for a zero result.
- R2: Op code 1 (subtract) gives result = reg − mem − (1 − C). C is set when no borrow occurs. V is set when the operands differ in sign and the result sign differs from reg. N and Z follow the result.
- R3: Op code 2 (compare) sets C when reg ≥ mem unsigned, and takes N and Z from the low byte of reg − mem. The result output carries reg unchanged, and V passes through.
- R4: Op codes 3, 4 and 5 (AND, OR, XOR of reg and mem) update only N and Z from the result.
- R5: Op code 6 (bit test) copies mem bit 7 into N and mem bit 6 into V, and sets Z when (reg AND mem) is zero. The result is reg unchanged and C passes through.
- R6: Op code 7 (shift left) moves reg bit 7 into C and fills bit 0 with 0. Op code 8 (logical shift right) moves reg bit 0 into C, fills bit 7 with 0 and therefore always clears N. Both set N and Z from the result.
- R7: Op code 9 (rotate left) moves the old C into bit 0 and reg bit 7 into C. Op code 10 (rotate right) moves the old C into bit 7 and reg bit 0 into C. N and Z follow the result.
- R8: Op codes 11 and 12 (increment and decrement reg) wrap modulo 256 and update only N and Z.
- R9: Status bits 4, 3 and 2 always pass through from the input, and the decimal bit (bit 3) has no effect on add or subtract. Output status bit 5 is always 1.
- R10: Op codes 13 to 15 return reg as the result and the input status with bit 5 forced to 1.
- R11: Outputs are registered. Inputs present before a rising edge appear after that edge, one new operation is accepted every cycle, and synchronous reset drives result 0x00 and status 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| reg_opnd | input | 8 | Register operand (accumulator or index register) |
| mem_opnd | input | 8 | Memory operand |
| stat_in | input | 8 | Current status byte |
| result_q | output | 8 | Registered result |
| stat_q | output | 8 | Registered updated status byte |

## Verification
The in-line assertions check the following on every cycle against the previous cycle's inputs:

- the untouched status bits pass through and bit 5 reads 1;
- N and Z agree with the result byte for every writing operation;
- logic, increment and decrement leave V and C alone;
- the add carry and the compare carry follow the unsigned relation;
- a logical right shift always leaves N clear;
- bit test copies the memory bits into N and V and returns the register unchanged.

Only the bench scenarios can show the exact result values, such as:

- the overflow cases of add and subtract;
- borrow through an incoming clear carry;
- rotation of the old carry into the vacated bit;
- wrap of increment and decrement;
- the decimal bit having no effect;
- the reset value and back-to-back throughput.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int STAT_W = 8;
  localparam int FLG_N  = 7;
  localparam int FLG_V  = 6;
  localparam int FLG_U  = 5;
  localparam int FLG_Z  = 1;
  localparam int FLG_C  = 0;

  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_ORA = 4'd4,
    OP_EOR = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_ASL = 2'd0,
    SH_LSR = 2'd1,
    SH_ROL = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  // Subtraction adds the one's complement; the carry then means "no borrow".
  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    sum   = wide[MSB:0];
    cout  = wide[DATA_W];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  // sel: 0 = AND, 1 = OR, 2 = XOR, 3 = AND (bit-test mask)
  always_comb begin
    unique case (sel)
      2'd1:    res = a | b;
      2'd2:    res = a ^ b;
      default: res = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic fill_lo;
  logic fill_hi;

  always_comb begin
    fill_lo = (kind == SH_ROL) ? cin : 1'b0;
    fill_hi = (kind == SH_ROR) ? cin : 1'b0;
    if (kind == SH_ASL || kind == SH_ROL) begin
      res  = {a[MSB-1:0], fill_lo};
      cout = a[MSB];
    end else begin
      res  = {fill_hi, a[MSB:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] reg_opnd,
  input  logic [DATA_W-1:0] mem_opnd,
  input  logic [STAT_W-1:0] stat_in,
  output logic [DATA_W-1:0] result_q,
  output logic [STAT_W-1:0] stat_q
);
  localparam int MSB = DATA_W - 1;
  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << FLG_U;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // Shared adder: add, subtract and compare
  logic              as_sub;
  logic              as_cin;
  logic [DATA_W-1:0] as_sum;
  logic              as_cout;
  logic              as_ovf;

  assign as_sub = (op_sel != OP_ADC);
  assign as_cin = (op_sel == OP_CMP) ? 1'b1 : stat_in[FLG_C];

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a    (reg_opnd),
    .b    (mem_opnd),
    .sub  (as_sub),
    .cin  (as_cin),
    .sum  (as_sum),
    .cout (as_cout),
    .ovf  (as_ovf)
  );

  // Logic unit
  logic [1:0]        lg_sel;
  logic [DATA_W-1:0] lg_res;

  always_comb begin
    unique case (op_sel)
      OP_ORA:  lg_sel = 2'd1;
      OP_EOR:  lg_sel = 2'd2;
      OP_BIT:  lg_sel = 2'd3;
      default: lg_sel = 2'd0;
    endcase
  end

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .sel (lg_sel),
    .a   (reg_opnd),
    .b   (mem_opnd),
    .res (lg_res)
  );

  // Shifter
  shift_kind_e       sh_kind;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;

  always_comb begin
    unique case (op_sel)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ROL:  sh_kind = SH_ROL;
      OP_ROR:  sh_kind = SH_ROR;
      default: sh_kind = SH_ASL;
    endcase
  end

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .kind (sh_kind),
    .a    (reg_opnd),
    .cin  (stat_in[FLG_C]),
    .res  (sh_res),
    .cout (sh_cout)
  );

  // Result and flag selection
  logic [DATA_W-1:0] nxt_res;
  logic [STAT_W-1:0] nxt_stat;
  logic [DATA_W-1:0] nz_src;
  logic              upd_nz;

  always_comb begin
    nxt_res  = reg_opnd;
    nxt_stat = stat_in;
    nz_src   = reg_opnd;
    upd_nz   = 1'b1;
    unique case (op_sel)
      OP_ADC, OP_SBC: begin
        nxt_res         = as_sum;
        nz_src          = as_sum;
        nxt_stat[FLG_C] = as_cout;
        nxt_stat[FLG_V] = as_ovf;
      end
      OP_CMP: begin
        nz_src          = as_sum;
        nxt_stat[FLG_C] = as_cout;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        nxt_res = lg_res;
        nz_src  = lg_res;
      end
      OP_BIT: begin
        upd_nz          = 1'b0;
        nxt_stat[FLG_N] = mem_opnd[MSB];
        nxt_stat[FLG_V] = mem_opnd[MSB-1];
        nxt_stat[FLG_Z] = (lg_res == '0);
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        nxt_res         = sh_res;
        nz_src          = sh_res;
        nxt_stat[FLG_C] = sh_cout;
      end
      OP_INC: begin
        nxt_res = reg_opnd + ONE;
        nz_src  = nxt_res;
      end
      OP_DEC: begin
        nxt_res = reg_opnd - ONE;
        nz_src  = nxt_res;
      end
      default: upd_nz = 1'b0;
    endcase
    if (upd_nz) begin
      nxt_stat[FLG_N] = nz_src[MSB];
      nxt_stat[FLG_Z] = (nz_src == '0);
    end
    nxt_stat[FLG_U] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      stat_q   <= STAT_RST;
    end else begin
      result_q <= nxt_res;
      stat_q   <= nxt_stat;
    end
  end

  // Assertions

  // R9: B, D and I bits are copied from the previous input; bit 5 reads 1
  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stat_q[4:2] == $past(stat_in[4:2])) && stat_q[FLG_U]);

  // R4 / R8: logic, increment and decrement keep V and C
  a_r4_vc_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) inside {OP_AND, OP_ORA, OP_EOR, OP_INC, OP_DEC}))
    |-> (stat_q[FLG_V] == $past(stat_in[FLG_V])) && (stat_q[FLG_C] == $past(stat_in[FLG_C])));

  // R1 / R2 / R4 / R6 / R7 / R8: N and Z agree with the written result
  a_r1_nz_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) <= 4'd12) && ($past(op_sel) != OP_CMP) && ($past(op_sel) != OP_BIT))
    |-> (stat_q[FLG_N] == result_q[MSB]) && (stat_q[FLG_Z] == (result_q == '0)));

  // R1: carry out of an add equals the unsigned overflow of the 9-bit sum
  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_ADC))
    |-> stat_q[FLG_C] == ((({1'b0, $past(reg_opnd)} + {1'b0, $past(mem_opnd)}
                             + {{DATA_W{1'b0}}, $past(stat_in[FLG_C])}) >> DATA_W) != 0));

  // R3: compare carry is the unsigned greater-or-equal relation; result is the register
  a_r3_cmp: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_CMP))
    |-> (stat_q[FLG_C] == ($past(reg_opnd) >= $past(mem_opnd))) && (result_q == $past(reg_opnd)));

  // R5: bit test copies the two upper memory bits and leaves the register
  a_r5_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_BIT))
    |-> (stat_q[FLG_N] == $past(mem_opnd[MSB])) && (stat_q[FLG_V] == $past(mem_opnd[MSB-1]))
        && (result_q == $past(reg_opnd)));

  // R6: logical shift right never leaves N set
  a_r6_lsr_n: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_LSR)) |-> !stat_q[FLG_N]);

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op_sel;
  logic [7:0] reg_opnd;
  logic [7:0] mem_opnd;
  logic [7:0] stat_in;
  logic [7:0] result_q;
  logic [7:0] stat_q;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .reg_opnd (reg_opnd),
    .mem_opnd (mem_opnd),
    .stat_in  (stat_in),
    .result_q (result_q),
    .stat_q   (stat_q)
  );

  // Vector fields: {req, op, reg, mem, stat_in, exp_result, exp_stat}
  localparam logic [51:0] VEC [NVEC] = '{
    {8'd1,  4'd0,  8'h50, 8'h50, 8'h20, 8'hA0, 8'hE0}, // R1 signed overflow
    {8'd1,  4'd0,  8'hFF, 8'h01, 8'h21, 8'h01, 8'h21}, // R1 carry in and out
    {8'd1,  4'd0,  8'hFF, 8'h01, 8'h20, 8'h00, 8'h23}, // R1 zero with carry
    {8'd2,  4'd1,  8'h50, 8'hB0, 8'h21, 8'hA0, 8'hE0}, // R2 borrow and overflow
    {8'd2,  4'd1,  8'h05, 8'h03, 8'h20, 8'h01, 8'h21}, // R2 clear C borrows one
    {8'd9,  4'd1,  8'h10, 8'h01, 8'h29, 8'h0F, 8'h29}, // R9 decimal bit ignored
    {8'd3,  4'd2,  8'h40, 8'h40, 8'h20, 8'h40, 8'h23}, // R3 equal
    {8'd3,  4'd2,  8'h10, 8'h20, 8'h61, 8'h10, 8'hE0}, // R3 less, V kept
    {8'd4,  4'd3,  8'hF0, 8'h0F, 8'hC1, 8'h00, 8'h63}, // R4 AND zero
    {8'd4,  4'd4,  8'h80, 8'h01, 8'h20, 8'h81, 8'hA0}, // R4 OR
    {8'd4,  4'd5,  8'hFF, 8'h0F, 8'h02, 8'hF0, 8'hA0}, // R4 XOR, bit5 forced
    {8'd5,  4'd6,  8'h01, 8'hC0, 8'h21, 8'h01, 8'hE3}, // R5 N V Z set
    {8'd5,  4'd6,  8'hFF, 8'h3F, 8'hE0, 8'hFF, 8'h20}, // R5 N V Z clear
    {8'd6,  4'd7,  8'h81, 8'h00, 8'h20, 8'h02, 8'h21}, // R6 shift left
    {8'd6,  4'd8,  8'h01, 8'h00, 8'hA0, 8'h00, 8'h23}, // R6 shift right
    {8'd7,  4'd9,  8'h80, 8'h00, 8'h21, 8'h01, 8'h21}, // R7 rotate left
    {8'd7,  4'd10, 8'h01, 8'h00, 8'h21, 8'h80, 8'hA1}, // R7 rotate right C in
    {8'd7,  4'd10, 8'h02, 8'h00, 8'h20, 8'h01, 8'h20}, // R7 rotate right no C
    {8'd8,  4'd11, 8'hFF, 8'h00, 8'h61, 8'h00, 8'h63}, // R8 increment wrap
    {8'd8,  4'd12, 8'h00, 8'h00, 8'h20, 8'hFF, 8'hA0}, // R8 decrement wrap
    {8'd10, 4'd13, 8'h5A, 8'h33, 8'hDF, 8'h5A, 8'hFF}, // R10 unused code
    {8'd9,  4'd12, 8'h01, 8'h00, 8'h3C, 8'h00, 8'h3E}  // R9 B D I pass through
  };

  task automatic check(input int req, input logic [7:0] exp_r, input logic [7:0] exp_s);
    n_chk++;
    if (result_q !== exp_r || stat_q !== exp_s) begin
      n_fail++;
      $display("FAIL R%0d: result %02h stat %02h, expected result %02h stat %02h",
               req, result_q, stat_q, exp_r, exp_s);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL R11: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; op_sel = 4'd0; reg_opnd = 8'h11; mem_opnd = 8'h22; stat_in = 8'hFF;
    repeat (2) @(negedge clk);
    check(11, 8'h00, 8'h20);   // R11 reset state
    rst = 1'b0;

    // Table walk, one vector per cycle (R11 throughput)
    for (int i = 0; i < NVEC; i++) begin
      {op_sel, reg_opnd, mem_opnd, stat_in} = VEC[i][43:16];
      @(negedge clk);
      check(int'(VEC[i][51:44]), VEC[i][15:8], VEC[i][7:0]);
    end

    // R11: reset mid-stream overrides a pending operation
    op_sel = 4'd0; reg_opnd = 8'h12; mem_opnd = 8'h34; stat_in = 8'h00;
    rst = 1'b1;
    @(negedge clk);
    check(11, 8'h00, 8'h20);
    rst = 1'b0;
    @(negedge clk);
    check(1, 8'h46, 8'h20);    // R1 plain add after reset

    // R2: subtract overflow from negative minus positive
    op_sel = 4'd1; reg_opnd = 8'h80; mem_opnd = 8'h01; stat_in = 8'h21;
    @(negedge clk);
    check(2, 8'h7F, 8'h61);

    // R3: compare greater, index register value
    op_sel = 4'd2; reg_opnd = 8'hF0; mem_opnd = 8'h01; stat_in = 8'h20;
    @(negedge clk);
    check(3, 8'hF0, 8'hA1);

    // R11: held inputs give the same output on consecutive cycles
    @(negedge clk);
    check(11, 8'hF0, 8'hA1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule